// File: doc/BRIEF.md
# DRAM Power-Up and Row Refresh Sequencer

This block sits beside a memory access controller that drives an asynchronous fast-page-mode DRAM array with 10-bit row addresses. Out of reset it holds the memory closed for a power-up wait, then asks the controller for a run of warm-up RAS cycles before it declares the memory ready. From then on it raises a refresh request at a fixed rate and supplies the row address for each RAS-only refresh cycle, stepping through every row in turn.

The controller owns the RAS pin. The sequencer only exchanges a request/grant/acknowledge handshake with it, so a refresh never breaks into a bus cycle already in progress. Refresh requests that cannot be served at once are counted, up to four. When that backlog is full, an urgent flag tells the controller to put refresh ahead of new accesses. The controller also reports every completed RAS cycle, of any kind. If none arrives for roughly the full retention window, the sequencer withdraws ready and repeats the warm-up run.

All wait lengths are given in nanoseconds together with the clock rate in kHz. They are turned into cycle counts at elaboration: the power-up wait is rounded up, and the refresh interval and idle limit are rounded down.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset is released, `rfsh_req_o` and `ready_o` stay low for exactly PAUSE_CYC clock edges (the power-up wait rounded up to whole cycles). `rfsh_req_o` rises on edge PAUSE_CYC.
- R2: After the wait, `ready_o` rises on the clock edge that samples the eighth `ras_done_i` pulse. It stays low after seven.
- R3: Once ready, a refresh becomes due every IVL_CYC cycles (the interval rounded down), counted from the edge on which `ready_o` rose.
- R4: `rfsh_row_o` starts at 0, advances by one only on an acknowledged refresh (`rfsh_ack_i` while a granted refresh is in flight), and wraps from 1023 to 0.
- R5: While ready, a raised `rfsh_req_o` stays high until `rfsh_gnt_i` is sampled with it. It is low from the grant until the acknowledge.
- R6: Refreshes that are due but not yet granted are counted up to a cap of four, and further due refreshes are dropped. `rfsh_urgent_o` is high exactly while the count is four. After the backlog is full, exactly four grants drain it.
- R7: While ready, if no `ras_done_i` pulse arrives for IDLE_CYC cycles (the retention window rounded down), `ready_o` falls on the edge IDLE_CYC cycles after the last pulse. Any RAS cycle, refresh or access, restarts that count.
- R8: After such a fall, `rfsh_req_o` is raised for warm-up cycles, and `ready_o` comes back only on the eighth further `ras_done_i` pulse.
- R9: During reset, `ready_o`, `rfsh_req_o` and `rfsh_urgent_o` are 0 and `rfsh_row_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_done_i | input | 1 | One-cycle pulse at the end of any RAS cycle |
| rfsh_gnt_i | input | 1 | Controller starts the requested refresh |
| rfsh_ack_i | input | 1 | Controller finished the granted refresh |
| ready_o | output | 1 | Array may be accessed |
| rfsh_req_o | output | 1 | A refresh (or warm-up) RAS cycle is wanted |
| rfsh_urgent_o | output | 1 | Backlog full; refresh goes before new accesses |
| rfsh_row_o | output | ROW_W | Row address for the RAS-only refresh |

## Verification
On every cycle, the embedded properties check four things. The wait state keeps the outputs quiet. The row moves only on an acknowledged refresh and wraps cleanly. A pending request is not withdrawn without a grant, and the backlog never passes its cap. Ready only rises on the eighth counted RAS cycle, and only falls after an idle expiry. The exact lengths can only be shown by the bench's timed scenarios: the wait, the refresh period and the idle limit. The same goes for the full sweep through all 1024 rows, the saturation and draining of the backlog, and the second warm-up after an artificial idle stretch.

// File: rtl/rfsh_pkg.sv
// Shared types and elaboration-time helpers for the refresh sequencer.
// Assumes clock rates given in kHz and delays in ns, both below 2^32.
package rfsh_pkg;

    typedef enum logic [1:0] {
        ST_PAUSE = 2'd0,
        ST_WARM  = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;

    // Converts a delay into clock cycles, rounding up or down, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned khz,
                                                 input int unsigned ns,
                                                 input bit round_up);
        longint unsigned prod;
        longint unsigned q;
        prod = 64'(khz) * 64'(ns);
        if (round_up)
            q = (prod + 64'd999_999) / 64'd1_000_000;
        else
            q = prod / 64'd1_000_000;
        if (q == 64'd0)
            q = 64'd1;
        return q[31:0];
    endfunction

endpackage

// File: rtl/rfsh_timer.sv
// Cycle timer: counts enabled cycles and pulses done_o on the LIMIT-th one,
// then starts over. Dropping run_i or raising clr_i restarts it from zero.
// Assumes LIMIT >= 1.
module rfsh_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic done_o
);
    localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Terminal count, masked while idle or being cleared.
    assign done_o = run_i && !clr_i && (cnt_q == LAST);

    // Advance the count while running; restart on clear, stop or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i || !run_i || done_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R3: the count never leaves its window.
    p_timer_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3: a stopped timer resumes from zero.
    p_timer_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);

endmodule

// File: rtl/rfsh_owed.sv
// Refresh backlog and handshake: counts due refreshes up to OWED_MAX, raises
// the request when one is due (or always during warm-up) and no refresh is
// in flight, and tracks the grant-to-acknowledge window.
// Assumes the controller acknowledges only a refresh it granted.
module rfsh_owed #(
    parameter int unsigned OWED_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic warm_i,
    input  logic gnt_i,
    input  logic ack_i,
    output logic req_o,
    output logic urgent_o,
    output logic step_o
);
    localparam int unsigned OW = $clog2(OWED_MAX + 1);
    localparam logic [OW-1:0] CAP = OW'(OWED_MAX);

    logic [OW-1:0] owed_q;
    logic          busy_q;
    logic          take;
    logic          inc;
    logic          dec;

    assign req_o    = !busy_q && (warm_i || owed_q != '0);
    assign take     = gnt_i && req_o;
    assign inc      = tick_i && (owed_q != CAP);
    assign dec      = take && (owed_q != '0);
    assign urgent_o = (owed_q == CAP);
    assign step_o   = ack_i && busy_q;

    // Backlog count: add due refreshes, remove granted ones, cleared in warm-up.
    always_ff @(posedge clk) begin
        if (!rst_n || warm_i)
            owed_q <= '0;
        else if (inc && !dec)
            owed_q <= owed_q + 1'b1;
        else if (dec && !inc)
            owed_q <= owed_q - 1'b1;
    end

    // In-flight flag from grant to acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (take)
            busy_q <= 1'b1;
        else if (ack_i)
            busy_q <= 1'b0;
    end

    // R6: backlog never passes its cap.
    p_owed_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        owed_q <= CAP);

    // R6: the full flag only comes on with a newly due refresh.
    p_urgent_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(urgent_o) |-> $past(tick_i));

    // R5: a pending request outside warm-up waits for its grant.
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !gnt_i && !warm_i) |=> req_o);

endmodule

// File: rtl/rfsh_row_ctr.sv
// Refresh row pointer: steps once per completed refresh and wraps at 2^ROW_W.
// Assumes step_i is a single-cycle completion strobe.
module rfsh_row_ctr #(
    parameter int unsigned ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [ROW_W-1:0] row_o
);
    logic [ROW_W-1:0] row_q;

    assign row_o = row_q;

    // Advance the row on each completed refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_q <= '0;
        else if (step_i)
            row_q <= row_q + 1'b1;
    end

    // R4: no movement without a completed refresh.
    p_row_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(row_q));

    // R4: the last row is followed by row zero.
    p_row_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && row_q == '1) |=> row_q == '0);

endmodule

// File: rtl/dram_refresh_seq.sv
// Power-up and refresh sequencer top. Holds off access for the power-up wait,
// collects INIT_CYCLES RAS cycles, then schedules periodic RAS-only refreshes
// and re-runs warm-up after an idle stretch. Assumes the controller pulses
// ras_done_i once per RAS cycle, including each refresh it performs.
module dram_refresh_seq #(
    parameter int unsigned CLK_KHZ     = 100_000,
    parameter int unsigned PAUSE_NS    = 500_000,
    parameter int unsigned REFRESH_NS  = 15_600,
    parameter int unsigned IDLE_NS     = 16_400_000,
    parameter int unsigned ROW_W       = 10,
    parameter int unsigned INIT_CYCLES = 8,
    parameter int unsigned OWED_MAX    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_done_i,
    input  logic             rfsh_gnt_i,
    input  logic             rfsh_ack_i,
    output logic             ready_o,
    output logic             rfsh_req_o,
    output logic             rfsh_urgent_o,
    output logic [ROW_W-1:0] rfsh_row_o
);
    import rfsh_pkg::*;

    localparam int unsigned PAUSE_CYC = ns_to_cycles(CLK_KHZ, PAUSE_NS, 1'b1);
    localparam int unsigned IVL_CYC   = ns_to_cycles(CLK_KHZ, REFRESH_NS, 1'b0);
    localparam int unsigned IDLE_CYC  = ns_to_cycles(CLK_KHZ, IDLE_NS, 1'b0);
    localparam int unsigned WARM_W    = $clog2(INIT_CYCLES + 1);
    localparam logic [WARM_W-1:0] WARM_LAST = WARM_W'(INIT_CYCLES - 1);

    seq_state_e        state_q;
    logic [WARM_W-1:0] warm_cnt_q;
    logic              pause_done;
    logic              ivl_tick;
    logic              idle_done;
    logic              in_run;
    logic              in_warm;
    logic              step;

    assign in_run  = (state_q == ST_RUN);
    assign in_warm = (state_q == ST_WARM);
    assign ready_o = in_run;

    rfsh_timer #(.LIMIT(PAUSE_CYC)) u_pause (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_PAUSE),
        .clr_i  (1'b0),
        .done_o (pause_done)
    );

    rfsh_timer #(.LIMIT(IVL_CYC)) u_ivl (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (in_run),
        .clr_i  (1'b0),
        .done_o (ivl_tick)
    );

    rfsh_timer #(.LIMIT(IDLE_CYC)) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (in_run),
        .clr_i  (ras_done_i),
        .done_o (idle_done)
    );

    rfsh_owed #(.OWED_MAX(OWED_MAX)) u_owed (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (ivl_tick),
        .warm_i   (in_warm),
        .gnt_i    (rfsh_gnt_i),
        .ack_i    (rfsh_ack_i),
        .req_o    (rfsh_req_o),
        .urgent_o (rfsh_urgent_o),
        .step_o   (step)
    );

    rfsh_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .row_o  (rfsh_row_o)
    );

    // Phase sequencing: wait, warm-up, run, and fall back to warm-up on idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PAUSE;
        end else begin
            unique case (state_q)
                ST_PAUSE: if (pause_done) state_q <= ST_WARM;
                ST_WARM:  if (ras_done_i && warm_cnt_q == WARM_LAST) state_q <= ST_RUN;
                ST_RUN:   if (idle_done) state_q <= ST_WARM;
                default:  state_q <= ST_PAUSE;
            endcase
        end
    end

    // Warm-up RAS cycle count, held at zero outside warm-up.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_warm)
            warm_cnt_q <= '0;
        else if (ras_done_i)
            warm_cnt_q <= warm_cnt_q + 1'b1;
    end

    // R1: nothing leaves the block during the power-up wait.
    p_pause_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSE) |-> (!ready_o && !rfsh_req_o));

    // R2: ready comes only with the last of the warm-up RAS cycles.
    p_ready_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(ras_done_i) && $past(warm_cnt_q) == WARM_LAST));

    // R7: ready is only withdrawn by an idle expiry.
    p_ready_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> $past(idle_done));

    // R8: after an idle expiry the block is back in warm-up, asking for RAS.
    p_rewarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && idle_done) |=> (in_warm && warm_cnt_q == '0));

endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;

    localparam int PAUSE_CYC = 200;
    localparam int IVL       = 50;
    localparam int IDLE      = 2000;
    localparam int ROWS      = 1024;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ras_done;
    logic       gnt;
    logic       ack;
    logic       ready;
    logic       req;
    logic       urgent;
    logic [9:0] row;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int exp_next = 0;
    int row_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_refresh_seq #(
        .CLK_KHZ(100_000), .PAUSE_NS(2_000), .REFRESH_NS(500),
        .IDLE_NS(20_000), .ROW_W(10), .INIT_CYCLES(8), .OWED_MAX(4)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ras_done_i(ras_done), .rfsh_gnt_i(gnt),
        .rfsh_ack_i(ack), .ready_o(ready), .rfsh_req_o(req),
        .rfsh_urgent_o(urgent), .rfsh_row_o(row)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: waits for a request, grants it, then completes the refresh.
    task automatic service();
        int guard = 0;
        while (!req && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        row_q.push_back(exp_next);
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        @(negedge clk);
        ack = 1'b1;
        ras_done = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        ras_done = 1'b0;
        exp_next = (exp_next + 1) % ROWS;
    endtask

    // Monitor: compares the offered row against the scoreboard at each grant.
    initial begin
        forever begin
            @(posedge gnt);
            #1;
            if (row_q.size() == 0)
                check("R4 row without expectation", int'(row), -1);
            else
                check("R4 row at grant", int'(row), row_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        int t0;
        rst_n = 1'b0; gnt = 1'b0; ack = 1'b0; ras_done = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 ready in reset", int'(ready), 0);
        check("R9 req in reset", int'(req), 0);
        check("R9 urgent in reset", int'(urgent), 0);
        check("R9 row in reset", int'(row), 0);

        // R1: power-up wait length
        rst_n = 1'b1;
        n = 0;
        while (!req && n < 1000) begin
            @(negedge clk);
            n++;
            if (!req) check("R1 ready held in wait", int'(ready), 0);
        end
        check("R1 wait length", n, PAUSE_CYC);

        // R2: eight warm-up cycles
        for (int i = 0; i < 7; i++) service();
        check("R2 not ready after seven", int'(ready), 0);
        service();
        check("R2 ready after eight", int'(ready), 1);

        // R3: first interval and steady period
        n = 0;
        while (!req && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check("R3 first interval", n, IVL);
        t0 = cyc;
        service();
        while (!req) @(negedge clk);
        check("R3 period", cyc - t0, IVL);

        // R4: full sweep across every row with wrap
        for (int i = 0; i < ROWS + 4; i++) begin
            service();
            if (exp_next == 0) check("R4 wrap to zero", int'(row), 0);
        end

        // R5 and R6: backlog builds to four and saturates
        while (!req) @(negedge clk);
        check("R6 not urgent with one owed", int'(urgent), 0);
        repeat (149) @(negedge clk);
        check("R5 request held without grant", int'(req), 1);
        check("R6 not urgent with three owed", int'(urgent), 0);
        @(negedge clk);
        check("R6 urgent with four owed", int'(urgent), 1);
        repeat (60) @(negedge clk);
        check("R6 urgent stays at cap", int'(urgent), 1);
        service();
        check("R6 urgent clears after grant", int'(urgent), 0);
        for (int i = 0; i < 3; i++) service();
        check("R6 four grants drain backlog", int'(req), 0);

        // R7: idle expiry measured from a plain access RAS cycle
        repeat (300) @(negedge clk);
        ras_done = 1'b1;
        @(negedge clk);
        ras_done = 1'b0;
        n = 0;
        while (ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check("R7 idle length", n, IDLE);

        // R8: second warm-up run
        check("R8 warm-up request", int'(req), 1);
        for (int i = 0; i < 7; i++) service();
        check("R8 not ready after seven", int'(ready), 0);
        service();
        check("R8 ready after eight", int'(ready), 1);

        repeat (5) @(negedge clk);
        check("R4 scoreboard empty", row_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule